// File: doc/BRIEF.md
# Memory Range Zero-Fill Engine

This block clears a contiguous stretch of memory on command. Software programs the lowest byte address and the highest byte address of the range, both inclusive, through a small register window, then writes an opcode into a command word. For the zero-fill opcode the engine splits the range into transfers of at most one chunk each and hands them, one at a time, to a memory write port. Each transfer carries an address, a byte count and an all-zero data word. When the final transfer has been accepted, the engine drops its busy flag and pulses done.

The register window takes 32-bit and 64-bit accesses. Each register is one 32-bit word. A 64-bit access covers the addressed word and the word that follows it, with the addressed word in the upper half. Each range bound is stored as a pair of words: a high word and a low word. A single 64-bit write at the pair's first offset therefore loads the complete bound. Any opcode other than zero-fill, or a range whose end lies below its start, raises a sticky error flag and leaves memory untouched.

Top module: `zfill_engine`

## Requirements
- R1: Register words: first-address high word at 0x3030 and low word at 0x3034; last-address high word at 0x3038 and low word at 0x303C; command word at 0x3800. Each bound is the value {high, low}, truncated to the memory address width. Each word reads back the last value stored in it. Any other offset reads as zero, and writes to it are dropped.
- R2: reg_wide=1 selects a 64-bit access. A wide write stores wdata[63:32] in the addressed word and wdata[31:0] in the next word (offset+4). A wide read returns {addressed word, next word}. A 32-bit access uses wdata[31:0]. A 32-bit read returns the word in rdata[31:0] with rdata[63:32] zero. Reads are combinational.
- R3: A write that puts 0x11 into the command word while idle starts a fill of last-first+1 bytes, beginning at first.
- R4: Chunk k has address first+k*CHUNK_BYTES and length min(CHUNK_BYTES, remaining bytes). The chunk lengths add up to exactly the range length.
- R5: A chunk is taken when mem_valid and mem_ready are both high at a clock edge. While mem_valid is high and mem_ready is low, mem_addr and mem_len hold. mem_data is always zero.
- R6: busy rises in the cycle after the accepted command write. It falls in the cycle after the final chunk is taken. mem_valid is never high without busy.
- R7: Writing any other value into the command word while idle sets err in the next cycle, starts no transfer and leaves busy low. err stays set until a fill is started.
- R8: done is high for exactly one cycle, the cycle after the final chunk is taken.
- R9: A command write while busy is ignored. It causes no restart and no change to err, and the command word keeps its value. Changes to the bound words during a fill do not alter that fill.
- R10: A zero-fill command with last below first sets err and issues no transfer.
- R11: After reset, busy, done, err and mem_valid are low, and every register word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| reg_addr | input | 14 | Byte offset in the register window |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational) |
| mem_valid | output | 1 | Chunk request valid |
| mem_ready | input | 1 | Memory accepts the chunk |
| mem_addr | output | MEM_AW | Chunk start byte address |
| mem_len | output | log2(CHUNK_BYTES)+1 | Chunk byte count |
| mem_data | output | DATA_W | Fill data, all zero |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky rejected-command flag |

## Verification
The hardest case to reach is a command write that arrives mid-fill, since it must be shown to have no effect. To create the window, the bench holds mem_ready low while a long range is pending. During that hold it writes an unknown opcode, a second fill command and new bound values. It then releases the port and compares every chunk against the originally programmed range. The chunk arithmetic is swept over many start addresses and lengths with a small chunk size, so that single-chunk, exact-multiple and ragged-tail splits all occur under a pseudo-random ready pattern.

// File: rtl/zfill_pkg.sv
package zfill_pkg;

    // register window geometry
    localparam int REG_AW = 14;
    localparam int WIDX_W = REG_AW - 2;

    // word offsets whose placement software relies on
    localparam logic [REG_AW-1:0] OFS_FIRST_HI = 14'h3030;
    localparam logic [REG_AW-1:0] OFS_FIRST_LO = 14'h3034;
    localparam logic [REG_AW-1:0] OFS_LAST_HI  = 14'h3038;
    localparam logic [REG_AW-1:0] OFS_LAST_LO  = 14'h303C;
    localparam logic [REG_AW-1:0] OFS_CMD      = 14'h3800;

    localparam logic [31:0] OP_ZERO_FILL = 32'h0000_0011;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FILL,
        CMD_REJECT
    } cmd_kind_e;

    typedef struct packed {
        logic [31:0] first_hi;
        logic [31:0] first_lo;
        logic [31:0] last_hi;
        logic [31:0] last_lo;
        logic [31:0] cmd;
    } zf_regs_t;

    function automatic logic [WIDX_W-1:0] word_of(input logic [REG_AW-1:0] ofs);
        return ofs[REG_AW-1:2];
    endfunction

endpackage

// File: rtl/zfill_regs.sv
module zfill_regs
    import zfill_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic              wide,
    input  logic [REG_AW-1:0] addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    input  logic              busy,
    output zf_regs_t          regs,
    output logic              cmd_wr,
    output logic [31:0]       cmd_val
);
    localparam int NW      = 5;
    localparam int CMD_IDX = 4;
    localparam logic [REG_AW-1:0] OFS [NW] =
        '{OFS_FIRST_HI, OFS_FIRST_LO, OFS_LAST_HI, OFS_LAST_LO, OFS_CMD};

    logic [WIDX_W-1:0]    widx;
    logic [WIDX_W-1:0]    widx_nx;
    logic [NW-1:0][31:0]  words;
    logic                 wr_cyc;

    assign widx    = word_of(addr);
    assign widx_nx = widx + WIDX_W'(1);
    assign wr_cyc  = req && we;

    for (genvar i = 0; i < NW; i++) begin : g_word
        logic        hit_top;
        logic        hit_bot;
        logic        wen;
        logic [31:0] wval;
        logic [31:0] q;

        assign hit_top = (widx == word_of(OFS[i]));
        assign hit_bot = wide && (widx_nx == word_of(OFS[i]));
        assign wval    = (hit_top && wide) ? wdata[63:32] : wdata[31:0];

        if (i == CMD_IDX) begin : g_cmd
            assign wen = wr_cyc && (hit_top || hit_bot) && !busy;
        end else begin : g_plain
            assign wen = wr_cyc && (hit_top || hit_bot);
        end

        always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (wen) q <= wval;
        end

        assign words[i] = q;
    end

    // command strobe to the decoder (raw, busy gating is done there)
    logic cmd_top;
    logic cmd_bot;
    assign cmd_top = (widx == word_of(OFS_CMD));
    assign cmd_bot = wide && (widx_nx == word_of(OFS_CMD));
    assign cmd_wr  = wr_cyc && (cmd_top || cmd_bot);
    assign cmd_val = (cmd_top && wide) ? wdata[63:32] : wdata[31:0];

    function automatic logic [31:0] lookup(input logic [WIDX_W-1:0] idx,
                                           input logic [NW-1:0][31:0] w);
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < NW; k++) begin
            if (idx == word_of(OFS[k])) v = w[k];
        end
        return v;
    endfunction

    always_comb begin
        if (wide) rdata = {lookup(widx, words), lookup(widx_nx, words)};
        else      rdata = {32'h0, lookup(widx, words)};
    end

    assign regs = '{first_hi: words[0], first_lo: words[1],
                    last_hi:  words[2], last_lo:  words[3],
                    cmd:      words[CMD_IDX]};

    // R9: command word is frozen while a fill runs
    a_r9_cmd_word_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(words[CMD_IDX]));

    // R2: a 32-bit read never returns upper bits
    a_r2_narrow_read_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !wide |-> rdata[63:32] == 32'h0);

endmodule

// File: rtl/zfill_cmd.sv
module zfill_cmd
    import zfill_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_val,
    input  logic              busy,
    input  logic [MEM_AW-1:0] first,
    input  logic [MEM_AW-1:0] last,
    output logic              start,
    output logic              err
);
    cmd_kind_e kind;

    always_comb begin
        kind = CMD_NONE;
        if (cmd_wr && !busy) begin
            if (cmd_val == OP_ZERO_FILL && last >= first) kind = CMD_FILL;
            else                                           kind = CMD_REJECT;
        end
    end

    assign start = (kind == CMD_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else begin
            case (kind)
                CMD_FILL:   err <= 1'b0;
                CMD_REJECT: err <= 1'b1;
                default:    err <= err;
            endcase
        end
    end

    // R7: an unknown opcode while idle raises err and starts nothing
    a_r7_unknown_op_flags: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && cmd_val != OP_ZERO_FILL) |=> (err && !busy));

    // R10: inverted range is rejected
    a_r10_inverted_range: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && last < first) |=> (err && !busy));

    // R9: err does not move while a fill runs
    a_r9_err_frozen_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(err));

endmodule

// File: rtl/zfill_seq.sv
module zfill_seq #(
    parameter int MEM_AW      = 32,
    parameter int CHUNK_BYTES = 4096,
    parameter int DATA_W      = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic [MEM_AW-1:0]              first,
    input  logic [MEM_AW-1:0]              last,
    output logic                           mem_valid,
    input  logic                           mem_ready,
    output logic [MEM_AW-1:0]              mem_addr,
    output logic [$clog2(CHUNK_BYTES):0]   mem_len,
    output logic [DATA_W-1:0]              mem_data,
    output logic                           busy,
    output logic                           done
);
    localparam int LEN_W = $clog2(CHUNK_BYTES) + 1;
    localparam int REM_W = MEM_AW + 1;
    localparam logic [REM_W-1:0]  CHUNK_REM  = REM_W'(CHUNK_BYTES);
    localparam logic [MEM_AW-1:0] CHUNK_STEP = MEM_AW'(CHUNK_BYTES);
    localparam logic [LEN_W-1:0]  CHUNK_LEN  = LEN_W'(CHUNK_BYTES);

    logic              busy_q;
    logic              done_q;
    logic [MEM_AW-1:0] addr_q;
    logic [REM_W-1:0]  rem_q;
    logic              tail;
    logic              fire;

    assign tail = (rem_q <= CHUNK_REM);
    assign fire = busy_q && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                addr_q <= first;
                rem_q  <= {1'b0, last} - {1'b0, first} + REM_W'(1);
            end else if (fire) begin
                if (tail) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rem_q  <= '0;
                end else begin
                    addr_q <= addr_q + CHUNK_STEP;
                    rem_q  <= rem_q - CHUNK_REM;
                end
            end
        end
    end

    assign mem_valid = busy_q;
    assign mem_addr  = addr_q;
    assign mem_len   = tail ? rem_q[LEN_W-1:0] : CHUNK_LEN;
    assign mem_data  = '0;
    assign busy      = busy_q;
    assign done      = done_q;

    // R5: request held steady while stalled
    a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

    // R4: every chunk is non-empty and within one chunk
    a_r4_len_in_bounds: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_len != '0 && mem_len <= CHUNK_LEN));

    // R8: done is a single-cycle pulse with busy already low
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_valid) ##1 !done);

    // R6: a tail handshake ends busy on the next cycle
    a_r6_busy_drops_after_tail: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && tail) |=> (!busy && done));

endmodule

// File: rtl/zfill_engine.sv
module zfill_engine
    import zfill_pkg::*;
#(
    parameter int MEM_AW      = 32,
    parameter int CHUNK_BYTES = 4096,
    parameter int DATA_W      = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_req,
    input  logic                         reg_we,
    input  logic                         reg_wide,
    input  logic [13:0]                  reg_addr,
    input  logic [63:0]                  reg_wdata,
    output logic [63:0]                  reg_rdata,
    output logic                         mem_valid,
    input  logic                         mem_ready,
    output logic [MEM_AW-1:0]            mem_addr,
    output logic [$clog2(CHUNK_BYTES):0] mem_len,
    output logic [DATA_W-1:0]            mem_data,
    output logic                         busy,
    output logic                         done,
    output logic                         err
);
    zf_regs_t          regs;
    logic              cmd_wr;
    logic [31:0]       cmd_val;
    logic              start;
    logic [63:0]       first64;
    logic [63:0]       last64;
    logic [MEM_AW-1:0] first;
    logic [MEM_AW-1:0] last;

    zfill_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (reg_req),
        .we      (reg_we),
        .wide    (reg_wide),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy    (busy),
        .regs    (regs),
        .cmd_wr  (cmd_wr),
        .cmd_val (cmd_val)
    );

    assign first64 = {regs.first_hi, regs.first_lo};
    assign last64  = {regs.last_hi,  regs.last_lo};
    assign first   = first64[MEM_AW-1:0];
    assign last    = last64[MEM_AW-1:0];

    zfill_cmd #(.MEM_AW(MEM_AW)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (cmd_wr),
        .cmd_val (cmd_val),
        .busy    (busy),
        .first   (first),
        .last    (last),
        .start   (start),
        .err     (err)
    );

    zfill_seq #(
        .MEM_AW      (MEM_AW),
        .CHUNK_BYTES (CHUNK_BYTES),
        .DATA_W      (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .first     (first),
        .last      (last),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len),
        .mem_data  (mem_data),
        .busy      (busy),
        .done      (done)
    );

    // R6: no request without busy
    a_r6_valid_implies_busy: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

    // R5: fill data is zero whenever offered
    a_r5_zero_data: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mem_data == '0);

endmodule

// File: tb/zfill_engine_test.sv
`timescale 1ns/1ps
module zfill_engine_test;
    localparam int AW = 16;
    localparam int CB = 16;
    localparam int LW = $clog2(CB) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_req = 1'b0, reg_we = 1'b0, reg_wide = 1'b0;
    logic [13:0]   reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          mem_valid, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_len;
    logic [63:0]   mem_data;
    logic          busy, done, err;

    always #4 clk = ~clk;

    zfill_engine #(.MEM_AW(AW), .CHUNK_BYTES(CB), .DATA_W(64)) uut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_data(mem_data), .busy(busy), .done(done), .err(err)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // memory-side responder and chunk monitor
    logic [7:0] lfsr = 8'h5A;
    bit         hold_low = 1'b0;
    int         n_accept = 0;
    int         n_bad_chunk = 0;
    int         n_done = 0;
    longint     exp_addr = 0;
    longint     exp_rem = 0;
    logic       rdy_q = 1'b0;
    assign mem_ready = rdy_q;

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy_q = hold_low ? 1'b0 : (lfsr[0] | lfsr[3]);
        if (done) n_done++;
        if (!rst && mem_valid && rdy_q) begin
            longint want_len;
            want_len = (exp_rem > CB) ? CB : exp_rem;
            n_accept++;
            if (longint'(mem_addr) != (exp_addr & 16'hFFFF) || longint'(mem_len) != want_len
                || mem_data != 64'h0) begin
                n_bad_chunk++;
                $display("FAIL R4 chunk actual=0x%0h/%0d expected=0x%0h/%0d",
                         mem_addr, mem_len, exp_addr, want_len);
            end
            exp_addr = exp_addr + CB;
            exp_rem  = exp_rem - want_len;
        end
    end

    task automatic wr(input logic [13:0] a, input logic [63:0] d, input bit wide);
        @(negedge clk);
        reg_req = 1'b1; reg_we = 1'b1; reg_wide = wide; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0; reg_wide = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input bit wide, output logic [63:0] d);
        @(negedge clk);
        reg_wide = wide; reg_addr = a;
        #1 d = reg_rdata;
        reg_wide = 1'b0;
    endtask

    // programs a range, fires a fill and checks the whole chunk stream
    task automatic run_fill(input longint first, input longint last);
        int acc0, done0, cyc;
        wr(14'h3030, 64'(first), 1'b1);
        wr(14'h3038, 64'(last), 1'b1);
        exp_addr = first; exp_rem = last - first + 1;
        acc0 = n_accept; done0 = n_done; n_bad_chunk = 0;
        wr(14'h3800, 64'h11, 1'b0);
        check(busy === 1'b1 || n_done != done0, "R6 busy after command", busy, 1);
        cyc = 0;
        while (n_done == done0 && cyc < 2000) begin
            @(negedge clk); #1; cyc++;
        end
        // now in the done cycle
        check(done === 1'b1 && busy === 1'b0, "R8 done with busy low", {done, busy}, 2'b10);
        check(n_bad_chunk == 0 && exp_rem == 0, "R4 chunk split", exp_rem, 0);
        check(n_accept - acc0 == int'((last - first + CB) / CB), "R3 chunk count",
              n_accept - acc0, (last - first + CB) / CB);
        @(negedge clk); #1;
        check(done === 1'b0, "R8 done one cycle", done, 0);
    endtask

    logic [63:0] rv;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check({busy, done, err, mem_valid} === 4'b0, "R11 outputs after reset",
              {busy, done, err, mem_valid}, 0);
        rd(14'h3030, 1'b1, rv); check(rv == 0, "R11 first pair zero", rv, 0);
        rd(14'h3038, 1'b1, rv); check(rv == 0, "R11 last pair zero", rv, 0);
        rd(14'h3800, 1'b0, rv); check(rv == 0, "R11 command zero", rv, 0);

        // R1 / R2 register access
        wr(14'h3030, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
        rd(14'h3030, 1'b0, rv); check(rv == 64'hAAAA_BBBB, "R2 wide write upper half", rv, 64'hAAAA_BBBB);
        rd(14'h3034, 1'b0, rv); check(rv == 64'hCCCC_DDDD, "R2 wide write lower half", rv, 64'hCCCC_DDDD);
        rd(14'h3030, 1'b1, rv); check(rv == 64'hAAAA_BBBB_CCCC_DDDD, "R2 wide read", rv, 64'hAAAA_BBBB_CCCC_DDDD);
        wr(14'h303C, 64'hFFFF_FFFF_1234_5678, 1'b0);
        rd(14'h3038, 1'b1, rv); check(rv == 64'h0000_0000_1234_5678, "R2 narrow write", rv, 64'h1234_5678);
        wr(14'h0100, 64'hDEAD_BEEF_DEAD_BEEF, 1'b1);
        rd(14'h0100, 1'b1, rv); check(rv == 0, "R1 unmapped reads zero", rv, 0);
        rd(14'h302C, 1'b1, rv); check(rv == 64'h0000_0000_AAAA_BBBB, "R1 R2 wide straddling unmapped", rv, 64'hAAAA_BBBB);
        rd(14'h303C, 1'b0, rv); check(rv == 64'h1234_5678, "R1 last low readback", rv, 64'h1234_5678);

        // R7 unknown opcode
        wr(14'h3030, 64'h10, 1'b1);
        wr(14'h3038, 64'h2F, 1'b1);
        begin
            int acc0;
            acc0 = n_accept;
            wr(14'h3800, 64'h22, 1'b0);
            #1 check(err === 1'b1 && busy === 1'b0, "R7 err set, idle", {err, busy}, 2'b10);
            repeat (5) @(negedge clk);
            #1 check(n_accept == acc0 && mem_valid === 1'b0, "R7 no memory write", n_accept - acc0, 0);
            rd(14'h3800, 1'b0, rv); check(rv == 32'h22, "R1 command readback", rv, 32'h22);
        end
        run_fill(64'h10, 64'h2F);
        check(err === 1'b0, "R7 err cleared by fill", err, 0);

        // R10 inverted range
        begin
            int acc0;
            acc0 = n_accept;
            wr(14'h3030, 64'h100, 1'b1);
            wr(14'h3038, 64'h0FF, 1'b1);
            wr(14'h3800, 64'h11, 1'b0);
            #1 check(err === 1'b1 && busy === 1'b0, "R10 inverted range rejected", {err, busy}, 2'b10);
            repeat (4) @(negedge clk);
            #1 check(n_accept == acc0, "R10 no memory write", n_accept - acc0, 0);
        end

        // R2: wide command write puts opcode in the upper half
        run_fill(64'h40, 64'h40);
        begin
            int done0;
            wr(14'h3030, 64'h200, 1'b1);
            wr(14'h3038, 64'h221, 1'b1);
            exp_addr = 64'h200; exp_rem = 64'h22; n_bad_chunk = 0; done0 = n_done;
            wr(14'h3800, 64'h0000_0011_0000_0000, 1'b1);
            #1 check(busy === 1'b1, "R2 wide command starts fill", busy, 1);
            while (n_done == done0) begin @(negedge clk); #1; end
            check(n_bad_chunk == 0 && exp_rem == 0, "R2 R4 wide-start split", exp_rem, 0);
        end

        // R9 commands and bound writes while busy
        begin
            int done0;
            wr(14'h3030, 64'h300, 1'b1);
            wr(14'h3038, 64'h3C7, 1'b1);
            exp_addr = 64'h300; exp_rem = 64'hC8; n_bad_chunk = 0; done0 = n_done;
            hold_low = 1'b1;
            wr(14'h3800, 64'h11, 1'b0);
            wr(14'h3800, 64'h22, 1'b0);
            #1 check(err === 1'b0, "R9 unknown op ignored while busy", err, 0);
            rd(14'h3800, 1'b0, rv); check(rv == 32'h11, "R9 command word unchanged", rv, 32'h11);
            wr(14'h3030, 64'h500, 1'b1);
            wr(14'h3800, 64'h11, 1'b0);
            #1 check(mem_addr == 16'h300 && mem_len == LW'(CB), "R5 R9 request held, no restart",
                     mem_addr, 16'h300);
            hold_low = 1'b0;
            while (n_done == done0) begin @(negedge clk); #1; end
            check(n_bad_chunk == 0 && exp_rem == 0, "R9 original range completed", exp_rem, 0);
        end

        // sweep of start addresses and lengths
        for (int s = 0; s < 6; s++) begin
            longint st;
            case (s)
                0: st = 0;  1: st = 1;  2: st = 15;
                3: st = 16; 4: st = 16'h1234; default: st = 16'hFF00;
            endcase
            for (int len = 1; len <= 50; len++) run_fill(st, st + len - 1);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule